// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two phase signals and the index mark of an incremental rotary encoder into a signed-direction position count. Each of the three inputs first passes through its own digital glitch filter, clocked by a shared divider off the system clock. The filtered phases then drive an edge decoder. The decoder works out the direction of motion and steps the counter once per edge of phase A (x2 resolution), or once per edge of either phase (x4 resolution). An equality compare against a programmable limit wraps the count. Single-cycle pulses flag a wrap past the limit in the up direction or below zero in the down direction.

The index input is optional. In the two index-reset modes, the index edge that matches the current direction reloads the counter. A separate mode ignores the encoder and runs the counter as a plain up/down timer at one step per system clock, with its direction set by a control bit. Software-style access goes through a small write/read port with four word addresses. The count and the direction are also driven out as plain outputs. The inputs are assumed to be synchronous to the clock already.

Top module: `qei_counter`

## Requirements
- R1: After reset the count is 0, the limit is all ones, the control word is 0, the direction status is 0 and both wrap pulses are low.
- R2: With the filter enabled, a filtered input takes a new value only when three consecutive filter samples agree on it, so a pulse lasting fewer than three samples never reaches the decoder.
- R3: Filter samples are taken once every 2^D system clocks, where D is control bits [6:4]; control bit 7 set enables the filters, and when it is clear the raw inputs go straight to the decoder.
- R4: Mode field (control bits [2:0]) 110 or 111 selects x4 decoding: every single-phase edge moves the count by one; an A edge counts up when A differs from B after the edge, and a B edge counts up when A equals B after the edge (A leading B is up).
- R5: Mode 100 or 101 selects x2 decoding: only A edges move the count, with the same direction rule; B edges alone leave the count unchanged.
- R6: A transition in which A and B change in the same filtered cycle moves neither the count nor the direction status.
- R7: Counting up from a count equal to the limit loads 0 and raises irq_roll for exactly the cycle in which the new count appears.
- R8: Counting down from 0 loads the limit and raises irq_under for exactly the cycle in which the new count appears.
- R9: In modes 100 and 110, a rising index edge while direction status is 1 loads 0, and a falling index edge while direction status is 0 loads the limit; modes 101 and 111 ignore the index.
- R10: Mode 001 counts one step per clock, up when control bit 3 is 1 and down when it is 0, wrapping as in R7 and R8; modes 000, 010 and 011 hold the count.
- R11: Direction status (read address 3, bit 0, and dir_o) holds the direction of the last decoded step, or control bit 3 in mode 001.
- R12: Write/read addresses: 0 control word, 1 count, 2 limit, 3 status; a write to address 1 or 2 loads that register on the next edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index mark |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| pos_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction status |
| irq_roll | output | 1 | One-cycle pulse on wrap past the limit |
| irq_under | output | 1 | One-cycle pulse on wrap below zero |

## Verification
With a divide value of 0, an input change made before edge k reaches the filter output at edge k+2. The decoder register sees it at edge k+3, and the count and any wrap pulse change at that same edge. With divide value D, the three samples fall on three successive ticks spaced 2^D clocks apart. Timer steps, register writes and index loads take effect on the first edge after the stimulus is seen. The bench updates a behavioural model at every rising edge from the same input values. It compares count, direction and both pulses at every falling edge, so every latency is checked to the exact cycle. Separate end-of-phase checks compare against hand-derived values.

// File: rtl/qei_pkg.sv
package qei_pkg;

   localparam int DIV_W = 3;

   typedef enum logic [2:0] {
      QM_OFF    = 3'b000,
      QM_TIMER  = 3'b001,
      QM_RSV2   = 3'b010,
      QM_RSV3   = 3'b011,
      QM_X2_IDX = 3'b100,
      QM_X2_LIM = 3'b101,
      QM_X4_IDX = 3'b110,
      QM_X4_LIM = 3'b111
   } qmode_e;

   typedef struct packed {
      logic             filt_en;
      logic [DIV_W-1:0] div;
      logic             tdir;
      qmode_e           mode;
   } qctrl_t;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_POS  = 2'd1;
   localparam logic [1:0] A_LIM  = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

endpackage

// File: rtl/qei_prescale.sv
module qei_prescale #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PRE_W = (1 << DIV_W) - 1;

   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
      $error("qei_prescale: DIV_W out of range");
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   span;

   always_comb begin
      span = ({{PRE_W{1'b0}}, 1'b1} << div) - 1'b1;
      tick = (pre_q & span[PRE_W-1:0]) == span[PRE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   p_tick_div0_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0) |-> tick);
endmodule

// File: rtl/qei_filter.sv
module qei_filter #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic din,
   output logic dout
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("qei_filter: DEPTH must be at least 2");
   end

   logic [DEPTH-2:0] hist_q;
   logic [DEPTH-2:0] hist_nx;
   logic             agree;
   logic             held_q;

   if (DEPTH > 2) begin : g_long
      assign hist_nx = {hist_q[DEPTH-3:0], din};
   end else begin : g_short
      assign hist_nx = din;
   end

   assign agree = (&{hist_q, din}) | ~(|{hist_q, din});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         held_q <= 1'b0;
      end else if (tick) begin
         hist_q <= hist_nx;
         if (agree) held_q <= din;
      end
   end

   assign dout = en ? held_q : din;

   p_change_on_tick_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held_q) |-> $past(tick));
   p_change_follows_in_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held_q) |-> (held_q == $past(din)));
endmodule

// File: rtl/qei_decode.sv
module qei_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic x4,
   input  logic pa,
   input  logic pb,
   input  logic pi,
   output logic step,
   output logic up,
   output logic idx_rise,
   output logic idx_fall
);
   logic pa_q, pb_q, pi_q;
   logic da, db;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_q <= 1'b0;
         pb_q <= 1'b0;
         pi_q <= 1'b0;
      end else begin
         pa_q <= pa;
         pb_q <= pb;
         pi_q <= pi;
      end
   end

   always_comb begin
      da       = pa ^ pa_q;
      db       = pb ^ pb_q;
      step     = x4 ? (da ^ db) : (da & ~db);
      up       = da ? (pa ^ pb) : ~(pa ^ pb);
      idx_rise = pi & ~pi_q;
      idx_fall = ~pi & pi_q;
   end

   p_no_double_step_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (pa != pa_q && pb != pb_q) |-> !step);
endmodule

// File: rtl/qei_poscnt.sv
module qei_poscnt
   import qei_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  qmode_e           mode,
   input  logic             tdir,
   input  logic             step,
   input  logic             up,
   input  logic             idx_rise,
   input  logic             idx_fall,
   input  logic             wr_pos,
   input  logic             wr_lim,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lim,
   output logic             dir,
   output logic             roll,
   output logic             under
);
   logic mv, mup, idx_hit, at_top, at_bot;

   always_comb begin
      mv  = 1'b0;
      mup = 1'b0;
      if (mode == QM_TIMER) begin
         mv  = 1'b1;
         mup = tdir;
      end else if (mode[2]) begin
         mv  = step;
         mup = up;
      end
      idx_hit = mode[2] & ~mode[0] & ((idx_rise & dir) | (idx_fall & ~dir));
      at_top  = mv &  mup & (cnt == lim);
      at_bot  = mv & ~mup & (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         lim   <= '1;
         dir   <= 1'b0;
         roll  <= 1'b0;
         under <= 1'b0;
      end else begin
         roll  <= ~wr_pos & ~idx_hit & at_top;
         under <= ~wr_pos & ~idx_hit & at_bot;
         if (wr_lim) lim <= wdata;
         if (wr_pos)       cnt <= wdata;
         else if (idx_hit) cnt <= dir ? '0 : lim;
         else if (at_top)  cnt <= '0;
         else if (at_bot)  cnt <= lim;
         else if (mv)      cnt <= mup ? cnt + 1'b1 : cnt - 1'b1;
         if (mode == QM_TIMER)     dir <= tdir;
         else if (mode[2] && step) dir <= up;
      end
   end

   p_roll_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      roll |-> (cnt == '0));
   p_under_lim_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      under |-> (cnt == $past(lim)));
   p_one_pulse_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(roll && under));
   p_off_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode[2:1]) == 2'b01 || $past(mode) == QM_OFF) && !$past(wr_pos)
      |-> $stable(cnt));
   p_unit_step_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_pos) && !$past(idx_hit) && !roll && !under
      |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)
           || cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/qei_counter.sv
module qei_counter
   import qei_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int FILT_DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_idx,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic [CNT_W-1:0] pos_o,
   output logic             dir_o,
   output logic             irq_roll,
   output logic             irq_under
);
   localparam int CTRL_W = $bits(qctrl_t);
   localparam int N_IN   = 3;

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("qei_counter: CNT_W narrower than the control word");
   end

   qctrl_t           ctrl_q;
   logic             tick;
   logic [N_IN-1:0]  raw, filt;
   logic             step, up, idx_rise, idx_fall;
   logic [CNT_W-1:0] cnt, lim;
   logic             dir;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctrl_q <= '0;
      else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= qctrl_t'(wr_data[CTRL_W-1:0]);
   end

   qei_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div(ctrl_q.div), .tick(tick)
   );

   assign raw = {enc_idx, enc_b, enc_a};

   for (genvar k = 0; k < N_IN; k++) begin : g_filt
      qei_filter #(.DEPTH(FILT_DEPTH)) u_f (
         .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_q.filt_en),
         .din(raw[k]), .dout(filt[k])
      );
   end

   qei_decode u_dec (
      .clk(clk), .rst_n(rst_n), .x4(ctrl_q.mode[1]),
      .pa(filt[0]), .pb(filt[1]), .pi(filt[2]),
      .step(step), .up(up), .idx_rise(idx_rise), .idx_fall(idx_fall)
   );

   qei_poscnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .tdir(ctrl_q.tdir),
      .step(step), .up(up), .idx_rise(idx_rise), .idx_fall(idx_fall),
      .wr_pos(wr_en && wr_addr == A_POS), .wr_lim(wr_en && wr_addr == A_LIM),
      .wdata(wr_data), .cnt(cnt), .lim(lim), .dir(dir),
      .roll(irq_roll), .under(irq_under)
   );

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
         A_POS:   rd_data = cnt;
         A_LIM:   rd_data = lim;
         default: rd_data = {{(CNT_W-1){1'b0}}, dir};
      endcase
   end

   assign pos_o = cnt;
   assign dir_o = dir;

   p_pos_write_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) && $past(wr_addr) == A_POS |-> (pos_o == $past(wr_data)));
endmodule

// File: tb/qei_counter_tb.sv
module qei_counter_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = 2'd1;
   logic [W-1:0] rd_data, pos_o;
   logic         dir_o, irq_roll, irq_under;

   always #5 clk = ~clk;

   qei_counter #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pos_o(pos_o), .dir_o(dir_o),
      .irq_roll(irq_roll), .irq_under(irq_under)
   );

   int    n_chk = 0, n_bad = 0;
   string cur_req = "R1";
   int    roll_seen = 0, under_seen = 0;
   bit    done = 0;

   // ---------------- behavioural reference model ----------------
   int m_cnt, m_lim, m_dir, m_roll, m_under;
   int m_mode, m_tdir, m_div, m_fen, m_pc;
   int m_last[3], m_run[3], m_fout[3], m_prev[3];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lim = 65535; m_dir = 0; m_roll = 0; m_under = 0;
         m_mode = 0; m_tdir = 0; m_div = 0; m_fen = 0; m_pc = 0;
         for (int k = 0; k < 3; k++) begin
            m_last[k] = 0; m_run[k] = 2; m_fout[k] = 0; m_prev[k] = 0;
         end
      end else begin
         int raw[3], eff[3];
         bit tick, ca, cb, mv, mup, stp, hit;
         raw[0] = enc_a; raw[1] = enc_b; raw[2] = enc_idx;
         tick = ((m_pc % (1 << m_div)) == ((1 << m_div) - 1));
         m_pc = (m_pc + 1) % 128;
         for (int k = 0; k < 3; k++) eff[k] = m_fen ? m_fout[k] : raw[k];
         ca = eff[0] != m_prev[0];
         cb = eff[1] != m_prev[1];
         mup = ca ? (eff[0] != eff[1]) : (eff[0] == eff[1]);
         stp = ((m_mode >> 1) & 1) ? (ca != cb) : (ca && !cb);
         mv = 0;
         if (m_mode == 1) begin mv = 1; mup = m_tdir; end
         else if (m_mode >= 4) mv = stp;
         hit = (m_mode == 4 || m_mode == 6) &&
               ((eff[2] && !m_prev[2] && m_dir == 1) || (!eff[2] && m_prev[2] && m_dir == 0));
         m_roll = 0; m_under = 0;
         if (wr_en && wr_addr == 2'd1) m_cnt = int'(wr_data);
         else if (hit) m_cnt = (m_dir == 1) ? 0 : m_lim;
         else if (mv && mup) begin
            if (m_cnt == m_lim) begin m_cnt = 0; m_roll = 1; end
            else m_cnt = (m_cnt + 1) % 65536;
         end else if (mv) begin
            if (m_cnt == 0) begin m_cnt = m_lim; m_under = 1; end
            else m_cnt = m_cnt - 1;
         end
         if (m_mode == 1) m_dir = m_tdir;
         else if (m_mode >= 4 && stp) m_dir = mup;
         if (wr_en && wr_addr == 2'd2) m_lim = int'(wr_data);
         if (wr_en && wr_addr == 2'd0) begin
            m_mode = wr_data[2:0]; m_tdir = wr_data[3];
            m_div = wr_data[6:4];  m_fen = wr_data[7];
         end
         if (tick) for (int k = 0; k < 3; k++) begin
            if (raw[k] == m_last[k]) m_run[k]++; else m_run[k] = 1;
            m_last[k] = raw[k];
            if (m_run[k] >= 3) m_fout[k] = raw[k];
         end
         for (int k = 0; k < 3; k++) m_prev[k] = eff[k];
      end
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, int'(pos_o), m_cnt);
         check(cur_req, int'(dir_o), m_dir);
         check("R7", int'(irq_roll), m_roll);
         check("R8", int'(irq_under), m_under);
         if (irq_roll)  roll_seen++;
         if (irq_under) under_seen++;
      end
   end

   // ---------------- stimulus helpers ----------------
   int qs = 0;

   function automatic logic [W-1:0] cw(int mode, int tdir, int div, int fen);
      return W'((fen << 7) | (div << 4) | (tdir << 3) | mode);
   endfunction

   task automatic wr(logic [1:0] a, logic [W-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quad(int n, bit fwd, int hold);
      for (int s = 0; s < n; s++) begin
         @(negedge clk);
         qs = fwd ? (qs + 1) % 4 : (qs + 3) % 4;
         enc_a = (qs == 1 || qs == 2);
         enc_b = (qs == 2 || qs == 3);
         idle(hold - 1);
      end
   endtask

   task automatic put(logic a, logic b, int st);
      @(negedge clk); enc_a = a; enc_b = b; qs = st;
   endtask

   task automatic rd(logic [1:0] a, string req, int exp);
      @(negedge clk); rd_addr = a; #1;
      check(req, int'(rd_data), exp);
      rd_addr = 2'd1;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("R1", int'(pos_o), 0);
      check("R1", int'(dir_o), 0);
      check("R1", int'(irq_roll | irq_under), 0);
      rd(2'd2, "R1", 65535);
      rd(2'd0, "R1", 0);

      cur_req = "R4";                                // x4, limit mode, filter on
      wr(2'd0, cw(7, 0, 0, 1));
      quad(8, 1, 6); idle(6);
      check("R4", int'(pos_o), 8);
      check("R11", int'(dir_o), 1);
      cur_req = "R11";
      quad(3, 0, 6); idle(6);
      check("R4", int'(pos_o), 5);
      check("R11", int'(dir_o), 0);
      rd(2'd3, "R11", 0);

      cur_req = "R5";                                // x2: A edges only
      wr(2'd0, cw(5, 0, 0, 1));
      quad(8, 1, 6); idle(6);
      check("R5", int'(pos_o), 9);

      cur_req = "R6";                                // both phases flip together
      put(1'b0, 1'b1, 3); idle(8);
      check("R6", int'(pos_o), 9);
      wr(2'd0, cw(7, 0, 0, 1));
      put(1'b1, 1'b0, 1); idle(8);
      check("R6", int'(pos_o), 9);
      check("R6", int'(dir_o), 1);

      cur_req = "R2";                                // 2-cycle glitch rejected
      @(negedge clk); enc_b = 1'b1; @(negedge clk); @(negedge clk); enc_b = 1'b0;
      idle(8);
      check("R2", int'(pos_o), 9);

      cur_req = "R3";                                // divide by 4
      wr(2'd0, cw(7, 0, 2, 1));
      @(negedge clk); enc_b = 1'b1; idle(8); enc_b = 1'b0;
      idle(16);
      check("R3", int'(pos_o), 9);
      quad(1, 1, 16); idle(16);
      check("R3", int'(pos_o), 10);
      wr(2'd0, cw(7, 0, 0, 1));

      cur_req = "R12";
      wr(2'd1, 16'd3);
      wr(2'd2, 16'd4);
      rd(2'd1, "R12", 3);
      rd(2'd2, "R12", 4);
      rd(2'd0, "R12", int'(cw(7, 0, 0, 1)));

      cur_req = "R7";
      roll_seen = 0;
      quad(2, 1, 6); idle(6);
      check("R7", int'(pos_o), 0);
      check("R7", roll_seen, 1);
      cur_req = "R8";
      under_seen = 0;
      quad(1, 0, 6); idle(6);
      check("R8", int'(pos_o), 4);
      check("R8", under_seen, 1);

      cur_req = "R9";                                // index reset modes
      wr(2'd0, cw(6, 0, 0, 1));
      wr(2'd1, 16'd2);
      @(negedge clk); enc_idx = 1'b1; idle(8);
      check("R9", int'(pos_o), 2);                   // reverse: rise ignored
      @(negedge clk); enc_idx = 1'b0; idle(8);
      check("R9", int'(pos_o), 4);                   // reverse: fall loads limit
      quad(1, 1, 6); idle(6);                        // forward, 4 -> 0
      wr(2'd1, 16'd2);
      @(negedge clk); enc_idx = 1'b1; idle(8);
      check("R9", int'(pos_o), 0);                   // forward: rise clears
      wr(2'd1, 16'd3);
      @(negedge clk); enc_idx = 1'b0; idle(8);
      check("R9", int'(pos_o), 3);                   // forward: fall ignored
      wr(2'd0, cw(7, 0, 0, 1));
      wr(2'd1, 16'd2);
      @(negedge clk); enc_idx = 1'b1; idle(8); enc_idx = 1'b0; idle(8);
      check("R9", int'(pos_o), 2);                   // limit mode ignores index

      cur_req = "R10";                               // timer mode
      wr(2'd2, 16'd9);
      wr(2'd1, 16'd0);
      roll_seen = 0;
      wr(2'd0, cw(1, 1, 0, 1));
      idle(20);
      wr(2'd0, cw(0, 1, 0, 1));
      check("R10", int'(pos_o), 2);
      check("R10", roll_seen, 2);
      idle(10);
      check("R10", int'(pos_o), 2);
      wr(2'd0, cw(1, 0, 0, 1));
      idle(1);
      wr(2'd0, cw(3, 0, 0, 1));
      check("R10", int'(pos_o), 9);
      check("R11", int'(dir_o), 0);
      idle(6);
      check("R10", int'(pos_o), 9);

      cur_req = "R3";                                // filter bypass
      wr(2'd2, 16'hFFFF);
      wr(2'd1, 16'd0);
      wr(2'd0, cw(7, 0, 0, 0));
      quad(4, 1, 1); idle(4);
      check("R3", int'(pos_o), 4);

      idle(4);
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule